// File: doc/BRIEF.md
# USB Full-Speed Transmit Serializer

This block is the transmit half of a full-speed USB front end. A link-layer engine streams packet bytes into it over an 8-bit bus guarded by a valid/ready pair. The block puts a SYNC field in front of the bytes and sends the bytes least significant bit first. It inserts stuff bits, NRZI-encodes the stream and closes the packet with an end-of-packet sequence. It drives single-ended D+/D- levels and an output enable toward an external analog driver. CRC bytes are not generated here: the engine sends them on the bus like any other data.

Timing comes from a bit-rate divider. The divider is held in reset between packets and restarts when a packet begins, so the first line symbol appears one clock after the start request is sampled. Each line symbol then lasts `BIT_DIV` clocks.

Back-pressure rules on the byte stream: while `tx_valid` is high, the sender must keep a valid byte on `tx_data`. A byte moves whenever `tx_valid` and `tx_ready` are both high at a rising clock edge. The sender must then present the next byte, or drop `tx_valid` if that byte was the last. `tx_ready` is high only while the one-byte holding register is empty. It therefore rises once per byte the shifter is about to need, and each transfer ends it. Dropping `tx_valid` ends the packet after every byte already accepted has left the line.

A two-bit mode input selects normal coding, a non-driving mode or a raw mode without stuffing or NRZI. The mode is captured at the start of each packet.

Top module: `usbtx_serializer`

## Requirements
- R1: When `tx_valid` is sampled high while the block is idle, `line_oe` rises and the first SYNC symbol appears one clock later, which is within the allowed window of one to two clocks. The one exception is the non-driving mode.
- R2: A byte is captured when `tx_valid` and `tx_ready` are both high at a rising edge. `tx_ready` is low in the clock that follows every such transfer. The number of transfers per packet equals the number of bytes offered.
- R3: In normal coding, the eight SYNC symbols are K J K J K J K K. After them come the data bytes in the order given, each byte least significant bit first.
- R4: Line encodings are J = (`line_dp`=1, `line_dm`=0), K = (0,1) and SE0 = (0,0). Both outputs are never high together. In normal coding, a 0 bit flips the line between J and K and a 1 bit keeps it. The level before SYNC counts as J.
- R5: In normal coding, a 0 is inserted after every six consecutive 1 bits. The run counts the final SYNC bit and continues across byte boundaries. The inserted bit starts a new run. A stuff bit that falls due after the last data bit is still sent before end-of-packet.
- R6: Every line symbol is held for exactly `BIT_DIV` clocks. Outputs change only on bit-rate strobes.
- R7: After the last data or stuff bit, the line shows two symbols of SE0 and then one symbol of J. `line_oe` falls `BIT_DIV` clocks after that J begins, and it is low whenever the block is idle.
- R8: With `opmode` = 2'b10 (raw), bits go to the line directly, 1 as J and 0 as K, with no stuffing. SYNC then reads K K K K K K K J. End-of-packet is unchanged.
- R9: With `opmode` = 2'b01 (non-driving), `line_oe` stays low for the whole packet. Bytes are still accepted through the handshake.
- R10: `opmode` = 2'b11 behaves exactly like 2'b00.
- R11: `opmode` is sampled only when a packet starts. Changing it during a packet does not alter that packet.
- R12: During and after reset, `line_oe` = 0, `line_dp` = 1, `line_dm` = 0 and `tx_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opmode | input | 2 | 00 normal, 01 non-driving, 10 raw, 11 as normal |
| tx_valid | input | 1 | Byte valid; rising starts a packet, falling ends it |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Holding register empty; byte taken at this edge if valid |
| line_dp | output | 1 | D+ level |
| line_dm | output | 1 | D- level |
| line_oe | output | 1 | Driver enable |

## Verification
The hardest case to reach is a stuff bit that falls due right after the final data bit. At that point the coder must stall one more symbol before it may start end-of-packet. The run that triggers it also has to start in the SYNC tail or carry across byte boundaries. The stimulus reaches this with chosen byte patterns: runs of 0xFF, a 0x7E that breaks the run, and a closing 0xFC whose top six ones end the packet on a full run. The bench computes the expected number of stuff bits from the same bit stream. A second case that is hard to reach is a mode change partway through a packet. The bench flips `opmode` to raw right after the first transfer and then checks that the line still carries normal coding.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  // Operating modes as seen on the opmode pins.
  typedef enum logic [1:0] {
    OPM_NORMAL = 2'b00,
    OPM_QUIET  = 2'b01,
    OPM_RAW    = 2'b10,
    OPM_SPARE  = 2'b11
  } opmode_e;

  // Per-strobe command from the sequencer to the line coder.
  typedef enum logic [2:0] {
    LC_HOLD,
    LC_BIT,
    LC_STUFF,
    LC_SE0,
    LC_IDLEJ,
    LC_RELEASE
  } line_cmd_e;

  // Packet sequencer states.
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_BITS,
    FS_SE0_2,
    FS_EOPJ,
    FS_TAIL
  } fsm_e;

  localparam int STUFF_RUN = 6;

endpackage

// File: rtl/usbtx_bitclk.sv
module usbtx_bitclk #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic stb
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  // Counter is parked at zero while idle so a packet's first strobe
  // lands on the first clock of activity.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stb = run && (cnt_q == '0);

endmodule

// File: rtl/usbtx_feeder.sv
module usbtx_feeder #(
  parameter int          W        = 8,
  parameter logic [W-1:0] SYNC_PAT = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_en,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  input  logic         preload,
  input  logic         take,
  output logic         bit_out,
  output logic         have_bit
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  hold_q;
  logic          hold_full_q;
  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;
  logic          capture;

  assign tx_ready = accept_en && tx_valid && !hold_full_q;
  assign capture  = tx_ready;
  assign have_bit = (left_q != '0) || hold_full_q;
  assign bit_out  = (left_q != '0) ? sh_q[0] : hold_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '0;
      left_q      <= '0;
    end else begin
      if (capture) begin
        hold_q      <= tx_data;
        hold_full_q <= 1'b1;
      end
      if (preload) begin
        sh_q   <= SYNC_PAT;
        left_q <= LW'(W);
      end else if (take) begin
        if (left_q != '0) begin
          sh_q   <= sh_q >> 1;
          left_q <= left_q - 1'b1;
        end else begin
          // capture needs an empty holding register, so it never meets this branch
          sh_q        <= hold_q >> 1;
          left_q      <= LW'(W - 1);
          hold_full_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/usbtx_line_enc.sv
module usbtx_line_enc
  import usbtx_pkg::*;
#(
  parameter int RUN = STUFF_RUN
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  line_cmd_e cmd,
  input  logic      bit_in,
  input  logic      drive_en,
  input  logic      code_en,
  output logic      stuff_due,
  output logic      line_dp,
  output logic      line_dm,
  output logic      line_oe
);
  localparam int OW = $clog2(RUN + 1);

  logic [OW-1:0] ones_q;
  logic          lvl_q;     // 1 = J, 0 = K
  logic          next_lvl;

  assign stuff_due = code_en && (ones_q == OW'(RUN));

  always_comb begin
    if (code_en) next_lvl = bit_in ? lvl_q : !lvl_q;
    else         next_lvl = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      lvl_q   <= 1'b1;
      line_dp <= 1'b1;
      line_dm <= 1'b0;
      line_oe <= 1'b0;
    end else if (clear) begin
      ones_q <= '0;
      lvl_q  <= 1'b1;
    end else begin
      case (cmd)
        LC_BIT: begin
          lvl_q   <= next_lvl;
          line_dp <= next_lvl;
          line_dm <= !next_lvl;
          line_oe <= drive_en;
          ones_q  <= (code_en && bit_in) ? ones_q + 1'b1 : '0;
        end
        LC_STUFF: begin
          lvl_q   <= !lvl_q;
          line_dp <= !lvl_q;
          line_dm <= lvl_q;
          line_oe <= drive_en;
          ones_q  <= '0;
        end
        LC_SE0: begin
          line_dp <= 1'b0;
          line_dm <= 1'b0;
          line_oe <= drive_en;
        end
        LC_IDLEJ: begin
          lvl_q   <= 1'b1;
          line_dp <= 1'b1;
          line_dm <= 1'b0;
          line_oe <= drive_en;
        end
        LC_RELEASE: begin
          line_dp <= 1'b1;
          line_dm <= 1'b0;
          line_oe <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/usbtx_serializer.sv
module usbtx_serializer
  import usbtx_pkg::*;
#(
  parameter int BIT_DIV = 5,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opmode,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe
);
  localparam logic [DATA_W-1:0] SYNC_PAT = DATA_W'(1) << (DATA_W - 1);

  fsm_e      state_q, state_d;
  opmode_e   mode_q;
  line_cmd_e cmd;
  logic      st_idle, start, bit_stb;
  logic      take, cur_bit, have_bit, stuff_due;
  logic      drive_en, code_en;

  assign st_idle  = (state_q == FS_IDLE);
  assign start    = st_idle && tx_valid;
  assign drive_en = (mode_q != OPM_QUIET);
  assign code_en  = (mode_q != OPM_RAW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      mode_q  <= OPM_NORMAL;
    end else begin
      state_q <= state_d;
      if (start) mode_q <= opmode_e'(opmode);
    end
  end

  // Stuff decision precedes the shifter; an empty shifter ends the packet.
  always_comb begin
    state_d = state_q;
    cmd     = LC_HOLD;
    take    = 1'b0;
    case (state_q)
      FS_IDLE: if (tx_valid) state_d = FS_BITS;
      FS_BITS: if (bit_stb) begin
        if (stuff_due) begin
          cmd = LC_STUFF;
        end else if (have_bit) begin
          cmd  = LC_BIT;
          take = 1'b1;
        end else begin
          cmd     = LC_SE0;
          state_d = FS_SE0_2;
        end
      end
      FS_SE0_2: if (bit_stb) begin
        cmd     = LC_SE0;
        state_d = FS_EOPJ;
      end
      FS_EOPJ: if (bit_stb) begin
        cmd     = LC_IDLEJ;
        state_d = FS_TAIL;
      end
      FS_TAIL: if (bit_stb) begin
        cmd     = LC_RELEASE;
        state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  usbtx_bitclk #(.DIV(BIT_DIV)) u_bitclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!st_idle),
    .stb   (bit_stb)
  );

  usbtx_feeder #(.W(DATA_W), .SYNC_PAT(SYNC_PAT)) u_feeder (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (state_q == FS_BITS),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .preload   (start),
    .take      (take),
    .bit_out   (cur_bit),
    .have_bit  (have_bit)
  );

  usbtx_line_enc #(.RUN(STUFF_RUN)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .cmd       (cmd),
    .bit_in    (cur_bit),
    .drive_en  (drive_en),
    .code_en   (code_en),
    .stuff_due (stuff_due),
    .line_dp   (line_dp),
    .line_dm   (line_dm),
    .line_oe   (line_oe)
  );

endmodule

// File: rtl/usbtx_serializer_chk.sv
module usbtx_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] opmode,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       line_dp,
  input logic       line_dm,
  input logic       line_oe,
  input logic       bit_stb,
  input logic       st_idle,
  input logic [1:0] mode_lat
);

  p_start_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && tx_valid && opmode != 2'b01) |-> ##2 line_oe)
    else $error("R1: line not driven two samples after start");

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready)
    else $error("R2: ready stayed high after a transfer");

  p_no_se1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_dp && line_dm))
    else $error("R4: both line outputs high");

  p_hold_between_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable({line_dp, line_dm, line_oe}))
    else $error("R6: line changed without a bit strobe");

  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !line_oe)
    else $error("R7: driver enabled while idle");

  p_quiet_no_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lat == 2'b01) |-> !line_oe)
    else $error("R9: driver enabled in non-driving mode");

endmodule

bind usbtx_serializer usbtx_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opmode   (opmode),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .line_dp  (line_dp),
  .line_dm  (line_dm),
  .line_oe  (line_oe),
  .bit_stb  (bit_stb),
  .st_idle  (st_idle),
  .mode_lat (mode_q)
);

// File: tb/usbtx_serializer_tb.sv
`timescale 1ns/1ps
module usbtx_serializer_tb;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] opmode = 2'b00;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, dp, dm, oe;

  usbtx_serializer #(.BIT_DIV(DIV), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .opmode(opmode), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .line_dp(dp), .line_dm(dm), .line_oe(oe)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  int  t_raise = 0, mon_mode = 0, exp_stuff = 0, exp_bytes = 0, pkts_seen = 0;
  bit  oe_hi_seen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // 0 = SE0, 1 = J, 2 = K, 3 = SE1
  function automatic int cur_sym();
    if (dp && !dm) return 1;
    if (!dp && dm) return 2;
    if (!dp && !dm) return 0;
    return 3;
  endfunction

  function automatic int calc_stuff(input logic [7:0] d[$]);
    int ones = 0, n = 0;
    logic [7:0] b;
    for (int k = 0; k <= d.size(); k++) begin
      b = (k == 0) ? 8'h80 : d[k-1];
      for (int j = 0; j < 8; j++) begin
        if (ones == 6) begin n++; ones = 0; end
        ones = b[j] ? ones + 1 : 0;
      end
    end
    if (ones == 6) n++;
    return n;
  endfunction

  always @(negedge clk) if (oe === 1'b1) oe_hi_seen = 1'b1;

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): actual=%0d expected<150000", cyc);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic hold_sym(input int s, inout int bad);
    repeat (DIV - 1) begin
      @(negedge clk);
      if (cur_sym() != s || oe !== 1'b1) bad++;
    end
  endtask

  task automatic next_sym(output int s, inout int bad);
    @(negedge clk);
    s = cur_sym();
    hold_sym(s, bad);
  endtask

  task automatic decode_packet();
    int s, prev, bad, ones, nbits, stuffs, got, guard, serr, e;
    bit raw, sync_ok, b, done;
    logic [7:0] acc;
    raw = (mon_mode == 2);
    bad = 0; serr = 0; acc = 8'h00;
    check((cyc - (t_raise + 1)) >= 1 && (cyc - (t_raise + 1)) <= 2, "R1",
          "first SYNC latency", cyc - (t_raise + 1), 1);
    s = cur_sym();
    hold_sym(s, bad);
    sync_ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) next_sym(s, bad);
      if (raw) e = (k == 7) ? 1 : 2;
      else     e = (k == 7) ? 2 : ((k % 2 == 0) ? 2 : 1);
      if (s != e) sync_ok = 1'b0;
    end
    check(sync_ok, raw ? "R8" : "R3", "SYNC symbols", s, e);
    prev = s; ones = 1; nbits = 0; stuffs = 0; got = 0; guard = 0; done = 1'b0;
    while (!done) begin
      next_sym(s, bad);
      guard++;
      if (s == 0 || guard > 4000) begin
        done = 1'b1;
      end else begin
        b = raw ? (s == 1) : (s == prev);
        prev = s;
        if (!raw && ones == 6) begin
          if (b) serr++;
          stuffs++;
          ones = 0;
        end else begin
          ones = b ? ones + 1 : 0;
          acc = {b, acc[7:1]};
          nbits++;
          if (nbits == 8) begin
            nbits = 0;
            got++;
            if (exp_q.size() > 0) begin
              e = exp_q.pop_front();
              check(acc == e[7:0], raw ? "R8" : "R3", "data byte", acc, e);
            end else begin
              check(1'b0, raw ? "R8" : "R3", "unexpected byte", acc, 0);
            end
          end
        end
      end
    end
    check(nbits == 0 && got == exp_bytes, "R7", "bytes before EOP", got, exp_bytes);
    check(stuffs == exp_stuff && serr == 0, "R5", "stuff bit count", stuffs, exp_stuff);
    next_sym(s, bad);
    check(s == 0, "R7", "second SE0", s, 0);
    next_sym(s, bad);
    check(s == 1, "R7", "closing J", s, 1);
    check(bad == 0, "R6", "symbol width violations", bad, 0);
    @(negedge clk);
    check(oe == 1'b0, "R7", "enable released after J", oe, 0);
    pkts_seen++;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (oe === 1'b1) decode_packet();
    end
  end

  task automatic send(input logic [1:0] m, input logic [7:0] d[$],
                      input bit do_flip, input logic [1:0] flip_to);
    int hs = 0;
    int seen0;
    bit quiet;
    quiet = (m == 2'b01);
    @(negedge clk);
    seen0 = pkts_seen;
    opmode = m;
    mon_mode = (m == 2'b10) ? 2 : 0;
    exp_bytes = d.size();
    exp_stuff = (m == 2'b10) ? 0 : calc_stuff(d);
    if (!quiet) foreach (d[i]) exp_q.push_back(d[i]);
    oe_hi_seen = 1'b0;
    t_raise = cyc;
    tx_valid = 1'b1;
    for (int i = 0; i < d.size(); i++) begin
      tx_data = d[i];
      while (tx_ready !== 1'b1) @(negedge clk);
      @(posedge clk);
      hs++;
      @(negedge clk);
      check(tx_ready == 1'b0, "R2", "ready low after transfer", tx_ready, 0);
      if (do_flip && i == 0) opmode = flip_to;
    end
    tx_valid = 1'b0;
    tx_data = 8'h00;
    repeat (40 * DIV) @(negedge clk);
    check(hs == d.size(), "R2", "transfers per packet", hs, d.size());
    if (quiet) begin
      check(!oe_hi_seen, "R9", "enable stayed low", oe_hi_seen, 0);
      check(pkts_seen == seen0, "R9", "no packet on line", pkts_seen - seen0, 0);
    end else begin
      check(pkts_seen == seen0 + 1, "R1", "packet appeared", pkts_seen - seen0, 1);
    end
    check(exp_q.size() == 0, quiet ? "R9" : "R3", "bytes left unsent", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : driver
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    // R12: state held by reset
    check(oe == 0 && dp == 1 && dm == 0 && tx_ready == 0, "R12", "outputs in reset",
          {oe, dp, dm, tx_ready}, 4'b0100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(oe == 0 && dp == 1 && dm == 0 && tx_ready == 0, "R12", "outputs after reset",
          {oe, dp, dm, tx_ready}, 4'b0100);

    q = {8'hA5, 8'h3C};               send(2'b00, q, 1'b0, 2'b00);   // R3 R4 R6
    q = {8'h00};                      send(2'b00, q, 1'b0, 2'b00);   // R4 toggles
    q = {8'hFF, 8'hFF, 8'h7E, 8'hFC}; send(2'b00, q, 1'b0, 2'b00);   // R5 trailing stuff
    q = {8'hFF, 8'h01};               send(2'b11, q, 1'b0, 2'b00);   // R10
    q = {8'hFF, 8'hFF, 8'h81};        send(2'b10, q, 1'b0, 2'b00);   // R8 raw
    q = {8'h12, 8'h34, 8'h56};        send(2'b01, q, 1'b0, 2'b00);   // R9 non-driving
    q = {8'hFF, 8'hFF, 8'hFF};        send(2'b00, q, 1'b1, 2'b10);   // R11 flip mid-packet
    q.delete();
    for (int i = 0; i < 16; i++) q.push_back(8'(i * 37 + 5));
    send(2'b00, q, 1'b0, 2'b00);                                     // R2 R3 long stream
    check(tx_ready == 0 && oe == 0, "R7", "idle after traffic", {tx_ready, oe}, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule